// File: doc/BRIEF.md
# Host Firmware-Space Window Translator

This block maps one window of a host's firmware address space onto the local bus. Software sets up the window through a small register port. The base register gives two 16-bit halves: where the window sits on the host side, and where it lands on the local side. The mask register, also split into halves, controls which of the upper address bits are compared, which are substituted and which pass through. Translation works only on address bits [31:16], so the window granularity is 64 KiB. The window is a power of two in size and must be aligned to that size. Software sets the mask's upper half to the inverse of (size-1) and its lower half to (size>>16)-1.

Each cycle with `req_valid` high is a host request. The block registers the outcome: one cycle later it raises either `xl_hit`, with the translated local address, or `xl_miss`, with the address bus held at zero. A request is serviced only when both window-enable bits are set.

A status word keeps two sticky event flags, each cleared by writing 1. It also holds a firmware-path mode bit, which a write of 1 sets. A write of 0 to any of these bits leaves it untouched.

Top module: `win_xlate`

## Requirements
- R1: After reset, `xl_hit`, `xl_miss`, `xl_addr` and `fw_mode` are 0, and every register reads 0.
- R2: A request hits when both enables are set and (req_addr[31:16] & ~mask[15:0]) equals (base[15:0] & ~mask[15:0]). Any other request misses.
- R3: On a hit, xl_addr[31:16] = (base[31:16] & mask[31:16]) | (req_addr[31:16] & mask[15:0]).
- R4: On a hit, xl_addr[15:0] equals req_addr[15:0].
- R5: The enable register (select 0) services the window only when bit 8 and bit 10 are both 1. With either bit at 0, every request misses.
- R6: `xl_hit` or `xl_miss` is high exactly one cycle after a cycle with `req_valid` high. Both are low one cycle after a cycle with `req_valid` low.
- R7: While `xl_miss` is high, or while no result is presented, `xl_addr` is 0.
- R8: Status bit 0 (select 3) is set by every miss. Writing 1 to it clears it and writing 0 leaves it alone. If a miss and a clear land in the same cycle, the flag stays set.
- R9: Status bit 1 is set by any request made while the window is disabled. It clears only on a write of 1, like bit 0.
- R10: Writing 1 to status bit 17 sets the mode bit, which drives `fw_mode`. Writing 0 to bit 17 does not clear it.
- R11: Base (select 1) and mask (select 2) read back all 32 bits as written. The enable register reads back only bits 8 and 10; its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 base, 2 mask, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Host request strobe |
| req_addr | input | 32 | Host firmware-space address |
| xl_hit | output | 1 | Registered: request fell inside the window |
| xl_miss | output | 1 | Registered: request was refused |
| xl_addr | output | 32 | Registered translated local address, 0 unless hit |
| fw_mode | output | 1 | Firmware-path mode bit |

## Verification
Requests are made with the window disabled, half-enabled and fully enabled. This separates the enable gating from the address match. Two mask setups are used: a 1 MiB window, where the low mask bits pass host bits through, and an exact 64 KiB window. Each gets addresses inside the window, next to its edge and well outside it, so that substitution and pass-through of the upper bits can be told apart. Back-to-back requests, idle gaps, and status writes that coincide with a miss test the one-cycle timing and the set-over-clear priority.

// File: rtl/win_pkg.sv
package win_pkg;
    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_BASE   = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    localparam int STAT_MISS_IDX = 0;
    localparam int STAT_OFF_IDX  = 1;
    localparam int STAT_COUNT    = 2;
endpackage

// File: rtl/win_regs.sv
module win_regs
    import win_pkg::*;
#(
    parameter int AW        = 32,
    parameter int ENA_A_BIT = 8,
    parameter int ENA_B_BIT = 10,
    parameter int MODE_BIT  = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  reg_sel_e              sel,
    input  logic [AW-1:0]         wdata,
    input  logic [STAT_COUNT-1:0] stat_set,
    output logic [AW-1:0]         rdata,
    output logic [AW-1:0]         base,
    output logic [AW-1:0]         mask,
    output logic                  win_en,
    output logic                  fw_mode
);
    logic                  ena_a_q, ena_b_q;
    logic [AW-1:0]         base_q, mask_q;
    logic [STAT_COUNT-1:0] stat_q;
    logic                  mode_q;
    logic [STAT_COUNT-1:0] stat_clr;

    assign stat_clr = (wr && sel == SEL_STATUS) ? wdata[STAT_COUNT-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_a_q <= 1'b0;
            ena_b_q <= 1'b0;
            base_q  <= '0;
            mask_q  <= '0;
            mode_q  <= 1'b0;
        end else if (wr) begin
            unique case (sel)
                SEL_ENABLE: begin
                    ena_a_q <= wdata[ENA_A_BIT];
                    ena_b_q <= wdata[ENA_B_BIT];
                end
                SEL_BASE:   base_q <= wdata;
                SEL_MASK:   mask_q <= wdata;
                SEL_STATUS: if (wdata[MODE_BIT]) mode_q <= 1'b1;
            endcase
        end
    end

    // Per-flag sticky status: an event set wins over a concurrent clear
    for (genvar g = 0; g < STAT_COUNT; g++) begin : g_stat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stat_q[g] <= 1'b0;
            else if (stat_set[g])
                stat_q[g] <= 1'b1;
            else if (stat_clr[g])
                stat_q[g] <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_ENABLE: begin
                rdata[ENA_A_BIT] = ena_a_q;
                rdata[ENA_B_BIT] = ena_b_q;
            end
            SEL_BASE:   rdata = base_q;
            SEL_MASK:   rdata = mask_q;
            SEL_STATUS: begin
                rdata[STAT_COUNT-1:0] = stat_q;
                rdata[MODE_BIT]       = mode_q;
            end
        endcase
    end

    assign base    = base_q;
    assign mask    = mask_q;
    assign win_en  = ena_a_q & ena_b_q;
    assign fw_mode = mode_q;

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[STAT_MISS_IDX]) |->
            $past(wr && sel == SEL_STATUS && wdata[STAT_MISS_IDX]));
    // R10
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(mode_q));
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_set[STAT_MISS_IDX] |=> stat_q[STAT_MISS_IDX]);
endmodule

// File: rtl/win_match.sv
module win_match #(
    parameter int AW = 32,
    parameter int HW = AW / 2
) (
    input  logic [AW-1:0] host_addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    input  logic          enable,
    output logic          hit,
    output logic [AW-1:0] xaddr
);
    logic [HW-1:0] host_hi, base_loc, base_host, keep_m, subst_m;

    assign host_hi   = host_addr[AW-1:HW];
    assign base_loc  = base[AW-1:HW];
    assign base_host = base[HW-1:0];
    assign subst_m   = mask[AW-1:HW];
    assign keep_m    = mask[HW-1:0];

    assign hit   = enable && ((host_hi & ~keep_m) == (base_host & ~keep_m));
    assign xaddr = {(base_loc & subst_m) | (host_hi & keep_m), host_addr[HW-1:0]};
endmodule

// File: rtl/win_xlate.sv
module win_xlate
    import win_pkg::*;
#(
    parameter int AW        = 32,
    parameter int ENA_A_BIT = 8,
    parameter int ENA_B_BIT = 10,
    parameter int MODE_BIT  = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          xl_hit,
    output logic          xl_miss,
    output logic [AW-1:0] xl_addr,
    output logic          fw_mode
);
    localparam int HW = AW / 2;

    logic [AW-1:0]         base, mask, xaddr_c;
    logic                  win_en, hit_c;
    logic [STAT_COUNT-1:0] stat_set;
    logic                  hit_q, miss_q;
    logic [AW-1:0]         addr_q;

    assign stat_set[STAT_MISS_IDX] = req_valid && !hit_c;
    assign stat_set[STAT_OFF_IDX]  = req_valid && !win_en;

    win_regs #(.AW(AW), .ENA_A_BIT(ENA_A_BIT), .ENA_B_BIT(ENA_B_BIT),
               .MODE_BIT(MODE_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel_e'(reg_sel)),
        .wdata(reg_wdata), .stat_set(stat_set), .rdata(reg_rdata),
        .base(base), .mask(mask), .win_en(win_en), .fw_mode(fw_mode)
    );

    win_match #(.AW(AW), .HW(HW)) u_match (
        .host_addr(req_addr), .base(base), .mask(mask), .enable(win_en),
        .hit(hit_c), .xaddr(xaddr_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            miss_q <= 1'b0;
            addr_q <= '0;
        end else begin
            hit_q  <= req_valid && hit_c;
            miss_q <= req_valid && !hit_c;
            addr_q <= (req_valid && hit_c) ? xaddr_c : '0;
        end
    end

    assign xl_hit  = hit_q;
    assign xl_miss = miss_q;
    assign xl_addr = addr_q;

    // R6
    answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (xl_hit || xl_miss));
    // R6
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!xl_hit && !xl_miss));
    // R7
    miss_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_miss |-> xl_addr == '0);
    // R4
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> xl_addr[HW-1:0] == $past(req_addr[HW-1:0]));
    // R5
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !win_en) |=> xl_miss);
endmodule

// File: tb/test_win_xlate.sv
module test_win_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        xl_hit, xl_miss, fw_mode;
    logic [31:0] xl_addr;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    bit          m_ea, m_eb, m_s0, m_s1, m_mode, e_hit, e_miss;
    bit [31:0]   m_base, m_mask, e_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    win_xlate i_win_xlate (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .xl_hit(xl_hit), .xl_miss(xl_miss),
        .xl_addr(xl_addr), .fw_mode(fw_mode)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] model_read(logic [1:0] s);
        bit [31:0] v = '0;
        case (s)
            2'd0: begin v[8] = m_ea; v[10] = m_eb; end
            2'd1: v = m_base;
            2'd2: v = m_mask;
            default: begin v[0] = m_s0; v[1] = m_s1; v[17] = m_mode; end
        endcase
        return v;
    endfunction

    task automatic tick(string tag);
        bit en, nh, nm;
        bit [15:0] hi, keep;
        bit [31:0] na;
        en   = m_ea && m_eb;
        hi   = req_addr[31:16];
        keep = m_mask[15:0];
        nh   = req_valid && en && ((hi & ~keep) == (m_base[15:0] & ~keep));
        nm   = req_valid && !nh;
        na   = nh ? {(m_base[31:16] & m_mask[31:16]) | (hi & keep), req_addr[15:0]} : 32'h0;
        @(posedge clk);
        #1;
        if (reg_wr) begin
            case (reg_sel)
                2'd0: begin m_ea = reg_wdata[8]; m_eb = reg_wdata[10]; end
                2'd1: m_base = reg_wdata;
                2'd2: m_mask = reg_wdata;
                default: begin
                    if (reg_wdata[0]) m_s0 = 1'b0;
                    if (reg_wdata[1]) m_s1 = 1'b0;
                    if (reg_wdata[17]) m_mode = 1'b1;
                end
            endcase
        end
        if (nm) m_s0 = 1'b1;
        if (req_valid && !en) m_s1 = 1'b1;
        e_hit = nh; e_miss = nm; e_addr = na;
        check({tag, " hit"},  {31'b0, xl_hit},  {31'b0, e_hit});
        check({tag, " miss"}, {31'b0, xl_miss}, {31'b0, e_miss});
        check({tag, " addr"}, xl_addr, e_addr);
        check({tag, " mode"}, {31'b0, fw_mode}, {31'b0, m_mode});
    endtask

    task automatic wr_reg(logic [1:0] s, logic [31:0] d, string tag);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        tick(tag);
        reg_wr = 1'b0;
    endtask

    task automatic req(logic [31:0] a, string tag);
        req_valid = 1'b1; req_addr = a;
        tick(tag);
        req_valid = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] s, string tag);
        reg_sel = s;
        #1;
        check(tag, reg_rdata, model_read(s));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 hit", {31'b0, xl_hit}, 32'h0);
        check("R1 miss", {31'b0, xl_miss}, 32'h0);
        check("R1 addr", xl_addr, 32'h0);
        check("R1 mode", {31'b0, fw_mode}, 32'h0);
        for (int s = 0; s < 4; s++) rd_reg(2'(s), "R1 reg");
        rst_n = 1'b1;
        tick("R1 idle");

        // R5 R9 disabled window refuses requests
        req(32'h0000_0000, "R5 disabled");
        rd_reg(2'd3, "R9 off flag");
        wr_reg(2'd1, 32'h9800_0E00, "R11 base");
        wr_reg(2'd2, 32'hFFF0_000F, "R11 mask");
        rd_reg(2'd1, "R11 base rd");
        rd_reg(2'd2, "R11 mask rd");
        wr_reg(2'd0, 32'h0000_0100, "R5 half");
        req(32'h0E05_1234, "R5 half enable");
        wr_reg(2'd0, 32'hFFFF_FFFF, "R11 enable");
        rd_reg(2'd0, "R11 enable rd");

        // R2 R3 R4 1 MiB window
        req(32'h0E05_1234, "R3 inside");
        req(32'h0E0F_FFFF, "R4 top edge");
        req(32'h0E10_0000, "R2 above");
        req(32'h0DFF_FFFF, "R2 below");
        tick("R6 idle");
        req(32'h0E00_0001, "R2 base");
        req(32'h8E03_0000, "R2 far");

        // R2 exact 64 KiB window
        wr_reg(2'd2, 32'hFFFF_0000, "R3 exact mask");
        req(32'h0E00_ABCD, "R3 exact hit");
        req(32'h0E01_ABCD, "R7 exact miss");

        // R8 R9 status write-1-to-clear
        wr_reg(2'd3, 32'h0000_0000, "R8 write0");
        rd_reg(2'd3, "R8 kept");
        wr_reg(2'd3, 32'h0000_0001, "R8 clear0");
        rd_reg(2'd3, "R8 cleared");
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h0000_0001;
        req_valid = 1'b1; req_addr = 32'h5555_0000;
        tick("R8 set wins");
        reg_wr = 1'b0; req_valid = 1'b0;
        rd_reg(2'd3, "R8 set wins rd");
        wr_reg(2'd3, 32'h0000_0003, "R9 clear");
        rd_reg(2'd3, "R9 cleared");

        // R10 mode bit
        wr_reg(2'd3, 32'h0002_0000, "R10 set");
        wr_reg(2'd3, 32'h0000_0000, "R10 write0");
        rd_reg(2'd3, "R10 rd");

        // R5 dropping one enable
        wr_reg(2'd0, 32'h0000_0400, "R5 fw only");
        req(32'h0E00_0000, "R5 fw only req");
        tick("R6 tail");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule